// File: doc/BRIEF.md
# I2C Bus Condition Detector

This block observes the clock and data lines of an I2C bus and reports the bus conditions that frame a transfer: Start, Repeated Start and Stop. Both lines first pass through a synchronizer and a persistence filter. Edges are then judged on the filtered values, by comparing each sample with the one taken a cycle earlier. Each condition produces a single-cycle pulse. A bus-busy level goes high on Start and returns low on Stop. A Start that arrives while the bus is already busy raises a separate restart pulse in addition to the normal start pulse.

A Stop is honoured only when the clock line has been low at least once since the most recent Start or Restart. A data line that dips and recovers while the clock stays high therefore reports only a Start. Two enable inputs select whether Start and Stop drive the interrupt request output. A force input overrides both enables, for operating modes in which these interrupts are always on.

The block also checks for a collision on Start. While the surrounding logic is preparing to drive a Start and has not yet pulled the data line low, a data line that already reads low raises the collision output.

Top module: `i2c_cond_detector`

## Requirements
- R1: After reset, and after a reset applied in the middle of a transfer, bus_busy, start_pulse, restart_pulse, stop_pulse, irq and collision are all 0.
- R2: A filtered SDA fall while filtered SCL is high in both the current and the previous sample gives exactly one start_pulse and sets bus_busy to 1.
- R3: A filtered SDA rise while filtered SCL is high gives exactly one stop_pulse and clears bus_busy, provided SCL has been low at least once while the bus was busy since the last Start.
- R4: If SDA falls and then rises while SCL stays high throughout, only the Start is reported: no stop_pulse, and bus_busy stays 1.
- R5: A Start seen while bus_busy is 1 gives start_pulse and restart_pulse in the same cycle. It clears the record that SCL has been low, so a following SDA rise without an intervening SCL low is not a Stop.
- R6: A level on either line that lasts fewer than FILT_LEN (default 3) consecutive synchronized samples is ignored, so no condition is reported.
- R7: When irq_force is 0, irq pulses together with start_pulse only if start_ie is 1, and together with stop_pulse only if stop_ie is 1. irq is never high without one of those pulses.
- R8: When irq_force is 1, irq pulses on every Start and every Stop, whatever start_ie and stop_ie are.
- R9: collision is 1 in the cycle after one in which gen_start_arm is 1, sda_drive is 0 and filtered SDA is 0. It is 0 whenever gen_start_arm or sda_drive rules this out.
- R10: SDA changes made while SCL is low report no condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw I2C clock line |
| sda_in | input | 1 | Raw I2C data line |
| start_ie | input | 1 | Interrupt enable for Start |
| stop_ie | input | 1 | Interrupt enable for Stop |
| irq_force | input | 1 | Force Start/Stop interrupts on, ignoring the enables |
| gen_start_arm | input | 1 | The surrounding logic is about to drive a Start |
| sda_drive | input | 1 | The surrounding logic is pulling SDA low |
| start_pulse | output | 1 | One-cycle pulse on Start or Restart |
| restart_pulse | output | 1 | One-cycle pulse on Restart |
| stop_pulse | output | 1 | One-cycle pulse on a valid Stop |
| bus_busy | output | 1 | Bus held between Start and Stop |
| irq | output | 1 | Interrupt request pulse |
| collision | output | 1 | Collision seen while preparing a Start |

## Verification
The assertions rely on the raw lines being asynchronous but slow compared with clk. Any real change must hold for at least FILT_LEN synchronized samples, and only one line may change at a time. The stimulus changes one line per step and holds it for ten cycles. Short glitches are applied only in the filter test, where nothing is expected to happen. The enable and force inputs are changed only while the bus is idle, so an interrupt is never judged against an enable that moved in the same cycle.

// File: rtl/i2c_cond_pkg.sv
// Package: shared types and defaults for the I2C bus condition detector.
// Assumes: nothing; holds declarations only.
package i2c_cond_pkg;
    // Default number of synchronizer flops per line.
    localparam int DEF_SYNC_STAGES = 2;
    // Default number of consecutive samples a new line level must persist.
    localparam int DEF_FILT_LEN    = 3;

    // Unregistered condition strobes passed from detector to interrupt logic.
    typedef struct packed {
        logic start;
        logic stop;
        logic restart;
    } cond_ev_t;
endpackage

// File: rtl/i2c_line_filter.sv
// Module: synchronizer plus persistence filter for one open-drain bus line.
// Assumes: line idles high; SYNC_STAGES >= 2; FILT_LEN >= 1.
// The output follows the synchronized input only after FILT_LEN consecutive
// samples that differ from the current output.
module i2c_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(FILT_LEN - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   out_q;
    logic                   sync_bit;

    assign sync_bit = sync_q[SYNC_STAGES-1];
    assign line_out = out_q;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
    end

    // Accept a new level only once it has persisted for FILT_LEN samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b1;
            cnt_q <= '0;
        end else if (sync_bit == out_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_MAX) begin
            out_q <= sync_bit;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The filtered level only moves towards a level the synchronizer showed.
    AST_FILT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_q) |-> (out_q == $past(sync_bit))); // R6
endmodule

// File: rtl/i2c_cond_detect.sv
// Module: Start / Restart / Stop detection, bus-busy tracking and Start
// collision check, working on the filtered SCL and SDA levels.
// Assumes: inputs are already synchronized and filtered, idle high.
module i2c_cond_detect
    import i2c_cond_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_f,
    input  logic     sda_f,
    input  logic     gen_start_arm,
    input  logic     sda_drive,
    output cond_ev_t ev,
    output logic     start_pulse,
    output logic     restart_pulse,
    output logic     stop_pulse,
    output logic     bus_busy,
    output logic     collision
);
    logic scl_p, sda_p;
    logic busy_q, low_seen_q;
    logic start_q, restart_q, stop_q, coll_q;
    logic scl_held_high;

    assign scl_held_high = scl_p & scl_f;

    // Decode edges from the previous and current filtered samples.
    always_comb begin
        ev.start   = scl_held_high & sda_p & ~sda_f;
        ev.stop    = scl_held_high & ~sda_p & sda_f & low_seen_q;
        ev.restart = scl_held_high & sda_p & ~sda_f & busy_q;
    end

    // Keep the previous filtered samples for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    // Track bus ownership and whether SCL went low since the last Start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            low_seen_q <= 1'b0;
        end else if (ev.start) begin
            busy_q     <= 1'b1;
            low_seen_q <= 1'b0;
        end else if (ev.stop) begin
            busy_q     <= 1'b0;
            low_seen_q <= 1'b0;
        end else if (busy_q && !scl_f) begin
            low_seen_q <= 1'b1;
        end
    end

    // Register the condition strobes into single-cycle output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q   <= 1'b0;
            restart_q <= 1'b0;
            stop_q    <= 1'b0;
        end else begin
            start_q   <= ev.start;
            restart_q <= ev.restart;
            stop_q    <= ev.stop;
        end
    end

    // Flag SDA already low while a Start is armed but not yet driven.
    always_ff @(posedge clk) begin
        if (!rst_n) coll_q <= 1'b0;
        else        coll_q <= gen_start_arm & ~sda_drive & ~sda_f;
    end

    assign start_pulse   = start_q;
    assign restart_pulse = restart_q;
    assign stop_pulse    = stop_q;
    assign bus_busy      = busy_q;
    assign collision     = coll_q;

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> busy_q); // R2
    AST_STOP_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        stop_q |-> !busy_q); // R3
    AST_NO_START_STOP_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_q && stop_q)); // R3
    AST_RESTART_IS_START: assert property (@(posedge clk) disable iff (!rst_n)
        restart_q |-> (start_q && $past(busy_q))); // R5
    AST_STOP_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        stop_q |-> $past(busy_q)); // R3
    AST_COLL_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        coll_q |-> ($past(gen_start_arm) && !$past(sda_drive))); // R9
endmodule

// File: rtl/i2c_cond_irq.sv
// Module: interrupt request for Start and Stop conditions.
// Assumes: strobes come from the detector in the cycle the condition is seen.
// The force input overrides both enables.
module i2c_cond_irq
    import i2c_cond_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  cond_ev_t ev,
    input  logic     start_ie,
    input  logic     stop_ie,
    input  logic     irq_force,
    output logic     irq
);
    logic irq_q;
    logic start_en, stop_en;

    assign start_en = start_ie | irq_force;
    assign stop_en  = stop_ie  | irq_force;

    // Raise a one-cycle request for each enabled condition.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= (ev.start & start_en) | (ev.stop & stop_en);
    end

    assign irq = irq_q;

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> ($past(ev.start) || $past(ev.stop))); // R7
endmodule

// File: rtl/i2c_cond_detector.sv
// Module: top of the I2C bus condition detector. Filters both lines, detects
// Start / Restart / Stop, tracks bus-busy, raises interrupts and checks for a
// collision on Start.
// Assumes: scl_in and sda_in are asynchronous, idle high, and change slowly
// compared with clk.
module i2c_cond_detector
    import i2c_cond_pkg::*;
#(
    parameter int SYNC_STAGES = DEF_SYNC_STAGES,
    parameter int FILT_LEN    = DEF_FILT_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic start_ie,
    input  logic stop_ie,
    input  logic irq_force,
    input  logic gen_start_arm,
    input  logic sda_drive,
    output logic start_pulse,
    output logic restart_pulse,
    output logic stop_pulse,
    output logic bus_busy,
    output logic irq,
    output logic collision
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] filt_lines;
    cond_ev_t           ev;

    assign raw_lines = {sda_in, scl_in};

    // One synchronizer and filter per bus line.
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        i2c_line_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN)
        ) filt_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_in  (raw_lines[g]),
            .line_out (filt_lines[g])
        );
    end

    i2c_cond_detect det_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_f         (filt_lines[0]),
        .sda_f         (filt_lines[1]),
        .gen_start_arm (gen_start_arm),
        .sda_drive     (sda_drive),
        .ev            (ev),
        .start_pulse   (start_pulse),
        .restart_pulse (restart_pulse),
        .stop_pulse    (stop_pulse),
        .bus_busy      (bus_busy),
        .collision     (collision)
    );

    i2c_cond_irq irq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .start_ie  (start_ie),
        .stop_ie   (stop_ie),
        .irq_force (irq_force),
        .irq       (irq)
    );

    AST_IRQ_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        ((start_pulse || stop_pulse) && $past(irq_force)) |-> irq); // R8
    AST_IRQ_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (start_pulse || stop_pulse)); // R7
endmodule

// File: tb/i2c_cond_detector_tb_top.sv
`timescale 1ns/1ps
module i2c_cond_detector_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_in = 1'b1, sda_in = 1'b1;
    logic start_ie = 1'b1, stop_ie = 1'b1, irq_force = 1'b0;
    logic gen_start_arm = 1'b0, sda_drive = 1'b0;
    logic start_pulse, restart_pulse, stop_pulse, bus_busy, irq, collision;

    int n_checks = 0;
    int n_fail   = 0;
    int n_st = 0, n_sp = 0, n_rs = 0, n_irq = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    i2c_cond_detector dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .start_ie(start_ie), .stop_ie(stop_ie), .irq_force(irq_force),
        .gen_start_arm(gen_start_arm), .sda_drive(sda_drive),
        .start_pulse(start_pulse), .restart_pulse(restart_pulse),
        .stop_pulse(stop_pulse), .bus_busy(bus_busy), .irq(irq),
        .collision(collision)
    );

    // Count output pulses; each is seen at the edge after it rose.
    always @(posedge clk) begin
        if (start_pulse)   n_st  <= n_st + 1;
        if (stop_pulse)    n_sp  <= n_sp + 1;
        if (restart_pulse) n_rs  <= n_rs + 1;
        if (irq)           n_irq <= n_irq + 1;
    end

    typedef struct packed {
        logic       scl;
        logic       sda;
        logic [3:0] st;
        logic [3:0] sp;
        logic [3:0] rs;
        logic       busy;
    } vec_t;

    // Cumulative expected counts after each single-line step.
    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b1, 4'd0, 4'd0, 4'd0, 1'b0},  // idle
        '{1'b1, 1'b0, 4'd1, 4'd0, 4'd0, 1'b1},  // R2 start
        '{1'b0, 1'b0, 4'd1, 4'd0, 4'd0, 1'b1},
        '{1'b0, 1'b1, 4'd1, 4'd0, 4'd0, 1'b1},  // R10 data while SCL low
        '{1'b1, 1'b1, 4'd1, 4'd0, 4'd0, 1'b1},
        '{1'b0, 1'b1, 4'd1, 4'd0, 4'd0, 1'b1},
        '{1'b0, 1'b0, 4'd1, 4'd0, 4'd0, 1'b1},  // R10
        '{1'b1, 1'b0, 4'd1, 4'd0, 4'd0, 1'b1},
        '{1'b1, 1'b1, 4'd1, 4'd1, 4'd0, 1'b0},  // R3 stop
        '{1'b1, 1'b0, 4'd2, 4'd1, 4'd0, 1'b1},  // R2 start
        '{1'b1, 1'b1, 4'd2, 4'd1, 4'd0, 1'b1},  // R4 no stop
        '{1'b0, 1'b1, 4'd2, 4'd1, 4'd0, 1'b1},
        '{1'b1, 1'b1, 4'd2, 4'd1, 4'd0, 1'b1},
        '{1'b1, 1'b0, 4'd3, 4'd1, 4'd1, 1'b1},  // R5 restart
        '{1'b1, 1'b1, 4'd3, 4'd1, 4'd1, 1'b1},  // R5 no stop after restart
        '{1'b0, 1'b1, 4'd3, 4'd1, 4'd1, 1'b1},
        '{1'b0, 1'b0, 4'd3, 4'd1, 4'd1, 1'b1},
        '{1'b1, 1'b0, 4'd3, 4'd1, 4'd1, 1'b1},
        '{1'b1, 1'b1, 4'd3, 4'd2, 4'd1, 1'b0}   // R3 stop
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic scl, input logic sda, input int n);
        @(negedge clk);
        scl_in = scl;
        sda_in = sda;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Start, one SCL low period, then Stop.
    task automatic frame();
        step(1'b1, 1'b0, 10);
        step(1'b0, 1'b0, 10);
        step(1'b1, 1'b0, 10);
        step(1'b1, 1'b1, 10);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int b_st, b_sp, b_rs, b_irq;
        do_reset();
        // R1 reset state
        chk("R1 busy after reset", bus_busy, 0);
        chk("R1 pulses after reset", start_pulse + stop_pulse + restart_pulse + irq, 0);
        chk("R1 collision after reset", collision, 0);

        // Vector walk over Start, data, Stop, the SDA-only dip and the Restart.
        b_st = n_st; b_sp = n_sp; b_rs = n_rs;
        for (int i = 0; i < NV; i++) begin
            step(VEC[i].scl, VEC[i].sda, 10);
            chk($sformatf("R2/R3 start count row %0d", i), n_st - b_st, int'(VEC[i].st));
            chk($sformatf("R3/R4 stop count row %0d", i), n_sp - b_sp, int'(VEC[i].sp));
            chk($sformatf("R5 restart count row %0d", i), n_rs - b_rs, int'(VEC[i].rs));
            chk($sformatf("R2/R3 busy row %0d", i), bus_busy, int'(VEC[i].busy));
        end

        // R6: SDA low for two samples only, with SCL high, is not a Start.
        b_st = n_st;
        @(negedge clk); sda_in = 1'b0;
        @(negedge clk); @(negedge clk); sda_in = 1'b1;
        repeat (10) @(negedge clk);
        chk("R6 short SDA glitch", n_st - b_st, 0);
        chk("R6 busy after glitch", bus_busy, 0);
        // R6: an SCL dip during a transfer is ignored too (no low history).
        step(1'b1, 1'b0, 10);
        @(negedge clk); scl_in = 1'b0;
        @(negedge clk); @(negedge clk); scl_in = 1'b1;
        repeat (10) @(negedge clk);
        b_sp = n_sp;
        step(1'b1, 1'b1, 10);
        chk("R6 SCL glitch gives no stop", n_sp - b_sp, 0);
        chk("R6 busy kept", bus_busy, 1);

        // R1: reset in the middle of a transfer clears busy.
        do_reset();
        chk("R1 busy after mid reset", bus_busy, 0);

        // R7: every combination of the enables, force off.
        for (int c = 0; c < 4; c++) begin
            start_ie = c[1];
            stop_ie  = c[0];
            b_irq = n_irq; b_st = n_st; b_sp = n_sp;
            frame();
            chk($sformatf("R7 irq count ie=%0d", c), n_irq - b_irq, c[1] + c[0]);
            chk($sformatf("R7 frame conds ie=%0d", c), (n_st - b_st) + (n_sp - b_sp), 2);
        end

        // R8: force on with enables off, and with both on.
        for (int c = 0; c < 4; c += 3) begin
            start_ie = c[1];
            stop_ie  = c[0];
            irq_force = 1'b1;
            b_irq = n_irq;
            frame();
            chk($sformatf("R8 forced irq ie=%0d", c), n_irq - b_irq, 2);
        end
        irq_force = 1'b0;

        // R9: collision only when armed, not driving, and SDA reads low.
        @(negedge clk); gen_start_arm = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 armed with SDA high", collision, 0);
        step(1'b0, 1'b0, 10);
        chk("R9 armed with SDA low", collision, 1);
        @(negedge clk); sda_drive = 1'b1;
        @(negedge clk);
        chk("R9 driving SDA", collision, 0);
        @(negedge clk); sda_drive = 1'b0; gen_start_arm = 1'b0;
        @(negedge clk);
        chk("R9 not armed", collision, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule